// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block lets synchronous logic read and write an external asynchronous static RAM with a 20-bit address and an 8-bit bidirectional data bus. The RAM's chip enable, output enable and write enable are all active low. On the user side a request carries an address, write data and a direction flag. The block accepts a request only while its ready output is high. A read returns its byte on a data output together with a one-cycle valid pulse.

The RAM's nanosecond limits are set as parameters in whole clock cycles, rounded up. These limits cover access time, cycle time, write strobe width, data and address setup, the delay before the RAM lets go of the bus after the write strobe falls, and the output-enable float time. From them the block works out how long the write strobe stays low, and how long it waits after each access before it takes the next one. There are two write styles, chosen by a parameter. In one, output enable stays high during writes and the shorter strobe limit applies. In the other, output enable stays low and the longer strobe limit applies. The block's own data drivers turn on only after the RAM can no longer be driving the bus.

Top module: `sram_seq_ctrl`

## Requirements
- R1: During reset and after it, until a request is accepted: chip enable, output enable and write enable are high (inactive), ready is low during reset and rsp_valid is low.
- R2: A read holds chip enable and output enable low and write enable high for exactly ACC_CYC cycles. The byte on the bus is captured at the last of these edges. rsp_valid then pulses high for one cycle with that byte on rsp_rdata, and all strobes are high again in that cycle.
- R3: In the default write style (WRITE_OE_LOW=0), a write holds chip enable and write enable low for exactly WLEN cycles and keeps output enable high. WLEN is the largest of WE_OEH_CYC, WE_HZ_CYC+DSU_CYC and ASU_CYC.
- R4: During a write, the block does not drive the data bus in the first WE_HZ_CYC cycles after write enable falls. From then until write end it drives the request's write data.
- R5: With WRITE_OE_LOW=1, output enable stays low during writes and the strobe length uses WE_OEL_CYC in place of WE_OEH_CYC. Data written this way reads back correctly.
- R6: While chip enable is low, the address on the RAM pins does not change.
- R7: With a request held pending, accesses start exactly RC_CYC cycles after a read starts and exactly WC_CYC cycles after a write starts, with the default timing of the test (never sooner for any parameters).
- R8: The block starts driving the bus no sooner than OHZ_CYC cycles after output enable last rose at the end of a read.
- R9: A request presented while ready is low is ignored: the RAM address keeps the previously accepted value until ready returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Request accepted on this edge when high together with req_valid |
| rsp_valid | output | 1 | One-cycle pulse: read data available |
| rsp_rdata | output | DATA_W | Captured read byte |
| mem_addr | output | ADDR_W | RAM address pins |
| mem_dq | inout | DATA_W | RAM bidirectional data bus |
| mem_ce_n | output | 1 | RAM chip enable, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_we_n | output | 1 | RAM write enable, active low |

## Verification
Two functions share one clock edge. On the edge that captures read data, the same edge also raises chip enable and output enable. On the edge where the recovery wait after an access runs out, a request that has been waiting is accepted. The bench keeps the request asserted across every access, so each acceptance falls on the first edge on which ready is high. It then checks that the distance between access starts equals the cycle-time figure exactly, and that the address held still while the request waited. Captured bytes are compared against a scoreboard queue. A read that follows a write checks that the edge releasing the strobes did not corrupt the byte. A write that follows a read checks the bus turnaround.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } seq_state_e;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_dq_pad.sv
module sram_dq_pad #(
    parameter int DATA_W = 8
) (
    input  logic              drv_en,
    input  logic [DATA_W-1:0] dout,
    output logic [DATA_W-1:0] din,
    inout  wire  [DATA_W-1:0] pad
);
    // Tri-state driver toward the RAM; the receive path is always open.
    assign pad = drv_en ? dout : {DATA_W{1'bz}};
    assign din = pad;
endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W       = 20,
    parameter int DATA_W       = 8,
    parameter int ACC_CYC      = 1,
    parameter int RC_CYC       = 1,
    parameter int WC_CYC       = 1,
    parameter int WE_OEH_CYC   = 1,
    parameter int WE_OEL_CYC   = 2,
    parameter int WE_HZ_CYC    = 1,
    parameter int DSU_CYC      = 1,
    parameter int ASU_CYC      = 1,
    parameter int OHZ_CYC      = 1,
    parameter int WRITE_OE_LOW = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              drv_en,
    output logic [DATA_W-1:0] drv_data,
    input  logic [DATA_W-1:0] bus_in
);
    // Derived timing, all in clock cycles.
    localparam int ACC     = imax(ACC_CYC, 1);
    localparam int DRV_DLY = imax(WE_HZ_CYC, 1);
    localparam int WE_SEL  = (WRITE_OE_LOW != 0) ? WE_OEL_CYC : WE_OEH_CYC;
    localparam int WLEN    = imax(imax(WE_SEL, DRV_DLY + DSU_CYC), imax(ASU_CYC, 1));
    localparam int REC_RD  = imax(0, imax(RC_CYC - ACC - 1, OHZ_CYC - DRV_DLY - 1));
    localparam int REC_WR  = imax(0, WC_CYC - WLEN - 1);
    localparam int CNT_W   = $clog2(imax(WLEN, ACC) + 1);
    localparam int REC_W   = $clog2(imax(REC_RD, REC_WR) + 2);
    localparam int WCHK_W  = $clog2(WLEN + 2);
    localparam int QCHK_W  = $clog2(OHZ_CYC + 2);

    typedef struct packed {
        seq_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic [REC_W-1:0]  rec;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdat;
        logic [DATA_W-1:0] rdat;
        logic              rvld;
        logic              ready;
        logic              ce_n;
        logic              oe_n;
        logic              we_n;
        logic              drv;
    } seq_regs_t;

    localparam seq_regs_t REGS_RST = '{
        st: ST_IDLE, cnt: '0, rec: '0, addr: '0, wdat: '0, rdat: '0,
        rvld: 1'b0, ready: 1'b0, ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, drv: 1'b0
    };

    seq_regs_t regs_d, regs_q;
    logic      oe_wr_lvl;

    // Output-enable level held during writes depends on the write style.
    generate
        if (WRITE_OE_LOW != 0) begin : g_oe_low_wr
            assign oe_wr_lvl = 1'b0;
        end else begin : g_oe_high_wr
            assign oe_wr_lvl = 1'b1;
        end
    endgenerate

    always_comb begin
        regs_d      = regs_q;
        regs_d.rvld = 1'b0;
        case (regs_q.st)
            ST_IDLE: begin
                if (regs_q.rec != '0) begin
                    regs_d.rec = regs_q.rec - REC_W'(1);
                end
                if (req_valid && regs_q.ready) begin
                    regs_d.addr = req_addr;
                    regs_d.ce_n = 1'b0;
                    regs_d.cnt  = '0;
                    if (req_write) begin
                        regs_d.st   = ST_WRITE;
                        regs_d.we_n = 1'b0;
                        regs_d.oe_n = oe_wr_lvl;
                        regs_d.wdat = req_wdata;
                    end else begin
                        regs_d.st   = ST_READ;
                        regs_d.oe_n = 1'b0;
                    end
                end
            end
            ST_READ: begin
                if (regs_q.cnt == CNT_W'(ACC - 1)) begin
                    regs_d.rdat = bus_in;
                    regs_d.rvld = 1'b1;
                    regs_d.ce_n = 1'b1;
                    regs_d.oe_n = 1'b1;
                    regs_d.st   = ST_IDLE;
                    regs_d.rec  = REC_W'(REC_RD);
                end else begin
                    regs_d.cnt = regs_q.cnt + CNT_W'(1);
                end
            end
            ST_WRITE: begin
                if (regs_q.cnt == CNT_W'(WLEN - 1)) begin
                    regs_d.we_n = 1'b1;
                    regs_d.ce_n = 1'b1;
                    regs_d.oe_n = 1'b1;
                    regs_d.drv  = 1'b0;
                    regs_d.st   = ST_IDLE;
                    regs_d.rec  = REC_W'(REC_WR);
                end else begin
                    regs_d.cnt = regs_q.cnt + CNT_W'(1);
                    if (regs_q.cnt == CNT_W'(DRV_DLY - 1)) begin
                        regs_d.drv = 1'b1;
                    end
                end
            end
            default: begin
                regs_d = REGS_RST;
            end
        endcase
        regs_d.ready = (regs_d.st == ST_IDLE) && (regs_d.rec == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= REGS_RST;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign req_ready = regs_q.ready;
    assign rsp_valid = regs_q.rvld;
    assign rsp_rdata = regs_q.rdat;
    assign mem_addr  = regs_q.addr;
    assign mem_ce_n  = regs_q.ce_n;
    assign mem_oe_n  = regs_q.oe_n;
    assign mem_we_n  = regs_q.we_n;
    assign drv_en    = regs_q.drv;
    assign drv_data  = regs_q.wdat;

    // Checker state: length of the current write strobe and cycles since the RAM last drove.
    logic [WCHK_W-1:0] we_low_cnt_q;
    logic [QCHK_W-1:0] rd_quiet_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_low_cnt_q   <= '0;
            rd_quiet_cnt_q <= QCHK_W'(OHZ_CYC);
        end else begin
            we_low_cnt_q <= mem_we_n ? '0 : we_low_cnt_q + WCHK_W'(1);
            if (!mem_ce_n && !mem_oe_n && mem_we_n) begin
                rd_quiet_cnt_q <= '0;
            end else if (rd_quiet_cnt_q < QCHK_W'(OHZ_CYC)) begin
                rd_quiet_cnt_q <= rd_quiet_cnt_q + QCHK_W'(1);
            end
        end
    end

    p_idle_strobes_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ce_n |-> (mem_we_n && !drv_en));

    p_valid_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_valid_strobes_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (mem_ce_n && mem_oe_n));

    p_we_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_low_cnt_q == WCHK_W'(WLEN)));

    p_drive_late_r4: assert property (@(posedge clk) disable iff (!rst_n)
        drv_en |-> (!mem_we_n && (we_low_cnt_q >= WCHK_W'(DRV_DLY))));

    p_no_fight_r4: assert property (@(posedge clk) disable iff (!rst_n)
        drv_en |-> !(mem_we_n && !mem_oe_n));

    p_addr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

    p_data_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_en && $past(drv_en)) |-> $stable(drv_data));

    p_turnaround_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drv_en) |-> (rd_quiet_cnt_q >= QCHK_W'(OHZ_CYC)));

    p_ready_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n));

endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl #(
    parameter int ADDR_W       = 20,
    parameter int DATA_W       = 8,
    parameter int ACC_CYC      = 1,
    parameter int RC_CYC       = 1,
    parameter int WC_CYC       = 1,
    parameter int WE_OEH_CYC   = 1,
    parameter int WE_OEL_CYC   = 2,
    parameter int WE_HZ_CYC    = 1,
    parameter int DSU_CYC      = 1,
    parameter int ASU_CYC      = 1,
    parameter int OHZ_CYC      = 1,
    parameter int WRITE_OE_LOW = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    inout  wire  [DATA_W-1:0] mem_dq,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n
);
    logic              drv_en;
    logic [DATA_W-1:0] drv_data;
    logic [DATA_W-1:0] bus_in;

    sram_ctrl_fsm #(
        .ADDR_W       (ADDR_W),
        .DATA_W       (DATA_W),
        .ACC_CYC      (ACC_CYC),
        .RC_CYC       (RC_CYC),
        .WC_CYC       (WC_CYC),
        .WE_OEH_CYC   (WE_OEH_CYC),
        .WE_OEL_CYC   (WE_OEL_CYC),
        .WE_HZ_CYC    (WE_HZ_CYC),
        .DSU_CYC      (DSU_CYC),
        .ASU_CYC      (ASU_CYC),
        .OHZ_CYC      (OHZ_CYC),
        .WRITE_OE_LOW (WRITE_OE_LOW)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_ready (req_ready),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .mem_addr  (mem_addr),
        .mem_ce_n  (mem_ce_n),
        .mem_oe_n  (mem_oe_n),
        .mem_we_n  (mem_we_n),
        .drv_en    (drv_en),
        .drv_data  (drv_data),
        .bus_in    (bus_in)
    );

    sram_dq_pad #(
        .DATA_W (DATA_W)
    ) u_pad (
        .drv_en (drv_en),
        .dout   (drv_data),
        .din    (bus_in),
        .pad    (mem_dq)
    );

endmodule

// File: tb/sram_seq_ctrl_tb_top.sv
`timescale 1ns/1ps

module sram_async_model (
    input  logic        clk,
    input  logic [19:0] addr,
    input  logic        ce_n,
    input  logic        oe_n,
    input  logic        we_n,
    inout  wire  [7:0]  dq
);
    logic [7:0] cells [bit [19:0]];
    logic [7:0] rd_val = 8'h00;

    // Level-sensitive write over the enable overlap, then refresh the read path.
    always @(negedge clk) begin
        if (!ce_n && !we_n) cells[addr] = dq;
        rd_val = cells.exists(addr) ? cells[addr] : 8'h00;
    end

    assign dq = (!ce_n && we_n && !oe_n) ? rd_val : 8'hzz;
endmodule

module sram_seq_ctrl_tb_top;
    localparam int ACC = 3, RC = 5, WC = 6, OEH = 2, OEL = 5, HZ = 2, DSU = 1, ASU = 2, OHZ = 4;
    localparam int W_MAIN = 3;   // largest of OEH, HZ+DSU, ASU
    localparam int W_ALT  = 5;   // largest of OEL, HZ+DSU, ASU

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    int checks = 0;
    int errs   = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Main instance
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [19:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rsp_valid, ce_n, oe_n, we_n;
    logic [7:0]  rsp_rdata;
    logic [19:0] mem_addr;
    wire  [7:0]  dq;

    sram_seq_ctrl #(.ACC_CYC(ACC), .RC_CYC(RC), .WC_CYC(WC), .WE_OEH_CYC(OEH), .WE_OEL_CYC(OEL),
                    .WE_HZ_CYC(HZ), .DSU_CYC(DSU), .ASU_CYC(ASU), .OHZ_CYC(OHZ), .WRITE_OE_LOW(0)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_dq(dq), .mem_ce_n(ce_n), .mem_oe_n(oe_n), .mem_we_n(we_n));

    sram_async_model ram_i (.clk(clk), .addr(mem_addr), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .dq(dq));

    // Alternate instance: output enable kept low during writes
    logic        req2_valid = 1'b0, req2_write = 1'b0;
    logic [19:0] req2_addr = '0;
    logic [7:0]  req2_wdata = '0;
    logic        req2_ready, rsp2_valid, ce2_n, oe2_n, we2_n;
    logic [7:0]  rsp2_rdata;
    logic [19:0] mem2_addr;
    wire  [7:0]  dq2;

    sram_seq_ctrl #(.ACC_CYC(ACC), .RC_CYC(RC), .WC_CYC(WC), .WE_OEH_CYC(OEH), .WE_OEL_CYC(OEL),
                    .WE_HZ_CYC(HZ), .DSU_CYC(DSU), .ASU_CYC(ASU), .OHZ_CYC(OHZ), .WRITE_OE_LOW(1)) dut_alt_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req2_valid), .req_write(req2_write), .req_addr(req2_addr),
        .req_wdata(req2_wdata), .req_ready(req2_ready), .rsp_valid(rsp2_valid), .rsp_rdata(rsp2_rdata),
        .mem_addr(mem2_addr), .mem_dq(dq2), .mem_ce_n(ce2_n), .mem_oe_n(oe2_n), .mem_we_n(we2_n));

    sram_async_model ram2_i (.clk(clk), .addr(mem2_addr), .ce_n(ce2_n), .oe_n(oe2_n), .we_n(we2_n), .dq(dq2));

    // Scoreboard state
    logic [7:0]  exp_mem [bit [19:0]];
    logic [7:0]  exp_q [$];
    logic [7:0]  exp2_q [$];
    logic [7:0]  cur_wdata = '0;
    logic [19:0] cur_addr = '0;
    logic [19:0] last_addr = '0;
    bit          seen_acc = 1'b0;

    // Driver: request stays asserted until accepted; expected bytes go to the queue.
    task automatic do_acc(input bit wr, input logic [19:0] a, input logic [7:0] d);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        while (!req_ready) begin
            if (seen_acc) chk("R9 pending request left address alone", mem_addr, last_addr);
            @(negedge clk);
        end
        @(posedge clk);
        if (wr) exp_mem[a] = d;
        else    exp_q.push_back(exp_mem.exists(a) ? exp_mem[a] : 8'h00);
        cur_wdata = d; cur_addr = a; last_addr = a; seen_acc = 1'b1;
        @(negedge clk);
    endtask

    task automatic do_acc2(input bit wr, input logic [19:0] a, input logic [7:0] d);
        req2_valid = 1'b1; req2_write = wr; req2_addr = a; req2_wdata = d;
        while (!req2_ready) @(negedge clk);
        @(posedge clk);
        if (!wr) exp2_q.push_back(d);
        @(negedge clk);
        req2_valid = 1'b0;
    endtask

    // Monitor for the main instance
    int  we_run = 0, ce_run = 0, last_ce_run = 0, oe_hi_run = 100, since_start = 0;
    bit  have_prev = 1'b0, prev_wr = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            since_start++;
            oe_hi_run = oe_n ? oe_hi_run + 1 : 0;
            if (!we_n) begin
                we_run++;
                chk("R3 output enable high during write", oe_n, 1'b1);
                if (we_run <= HZ) chk("R4 bus not driven early", (dq == cur_wdata), 1'b0);
                else              chk("R4 write data on bus", dq, cur_wdata);
                if (we_run == HZ + 1) chk("R8 turnaround after read", (oe_hi_run >= OHZ + 1), 1'b1);
            end else begin
                if (we_run != 0) chk("R3 write strobe length", we_run, W_MAIN);
                we_run = 0;
            end
            if (!ce_n) begin
                if (ce_run == 0) begin
                    if (have_prev) chk("R7 start-to-start spacing", since_start, prev_wr ? WC : RC);
                    if (we_n) chk("R2 read strobes", {oe_n, we_n}, 2'b01);
                    have_prev = 1'b1; prev_wr = !we_n; since_start = 0;
                end
                ce_run++;
                chk("R6 address stable while selected", mem_addr, cur_addr);
            end else begin
                if (ce_run != 0) last_ce_run = ce_run;
                ce_run = 0;
            end
            if (rsp_valid) begin
                chk("R2 read strobe duration", last_ce_run, ACC);
                chk("R2 strobes released with valid", {ce_n, oe_n, we_n}, 3'b111);
                if (exp_q.size() == 0) chk("R2 unexpected read data", 1'b1, 1'b0);
                else chk("R2 read data", rsp_rdata, exp_q.pop_front());
            end
        end
    end

    // Monitor for the alternate instance
    int we2_run = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!we2_n) begin
                we2_run++;
                chk("R5 output enable low during write", oe2_n, 1'b0);
            end else begin
                if (we2_run != 0) chk("R5 long write strobe", we2_run, W_ALT);
                we2_run = 0;
            end
            if (rsp2_valid) begin
                if (exp2_q.size() == 0) chk("R5 unexpected read data", 1'b1, 1'b0);
                else chk("R5 read back", rsp2_rdata, exp2_q.pop_front());
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog: actual=%0h expected=%0h", 1, 0);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (3) begin
            @(negedge clk);
            chk("R1 reset strobes", {ce_n, oe_n, we_n}, 3'b111);
            chk("R1 reset ready and valid", {req_ready, rsp_valid}, 2'b00);
        end
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 idle strobes after reset", {ce_n, oe_n, we_n, rsp_valid}, 4'b1110);

        do_acc(1'b1, 20'h12345, 8'hA5);
        do_acc(1'b1, 20'hFFFFF, 8'h3C);
        do_acc(1'b1, 20'h00000, 8'hC3);
        do_acc(1'b0, 20'h12345, 8'h00);
        do_acc(1'b0, 20'hFFFFF, 8'h00);
        do_acc(1'b0, 20'h00000, 8'h00);
        do_acc(1'b1, 20'h00001, 8'h7E);
        do_acc(1'b0, 20'h00001, 8'h00);
        do_acc(1'b1, 20'h00002, 8'h81);
        do_acc(1'b0, 20'h00002, 8'h00);
        do_acc(1'b1, 20'h12345, 8'h5A);
        do_acc(1'b0, 20'h12345, 8'h00);
        req_valid = 1'b0;
        repeat (12) @(negedge clk);
        chk("R2 all reads answered", exp_q.size(), 0);

        do_acc2(1'b1, 20'h0ABCD, 8'h96);
        do_acc2(1'b0, 20'h0ABCD, 8'h96);
        repeat (12) @(negedge clk);
        chk("R5 alternate reads answered", exp2_q.size(), 0);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule